// File: doc/BRIEF.md
# Reset Strap Sequencer with Self-Test Request

This block runs the processor reset sequence for a host bridge. Software arms an optional built-in self-test by pulsing a set on an enable bit, then starts a warm reset by writing a reset-control bit. The sequencer pulls the active-low processor reset, builds a power-on configuration (strap) vector and latches it into an internal register. The vector is the supplied base configuration with the self-test bit replaced by the armed request. The sequencer drives the vector onto the upper host address pins and the INIT pin, and releases the processor reset after a fixed setup count. After a fixed hold count it turns the pin drivers off, so that the pins go back to their normal bus use.

The address pins carry 29 strap bits (host address 31 down to 3). Index 0 of the strap output is address bit 3, so the default self-test index 6 lands on address bit 9. The setup and hold counts are measured in host clocks. Both are parameters.

Top module: `reset_strap_seq`

## Requirements
- R1: After reset, `cpu_rst_n_o` is 1, `strap_oe_o` is 0, `strap_addr_o` is 0, `strap_init_n_o` is 1, and `warm_bit_o` and `bist_en_o` are 0.
- R2: A `warm_wr_i` pulse sampled while the sequencer is idle makes `warm_bit_o` read 1 after that edge. At the next edge `cpu_rst_n_o` drops to 0 and `warm_bit_o` clears to 0.
- R3: While driven, strap bit `BIST_IDX` (default 6) equals the armed self-test request. Every other bit of `strap_addr_o` equals `base_strap_i`, and `strap_init_n_o` equals `base_init_n_i`. All of these are captured at the edge where `strap_oe_o` rises.
- R4: A `bist_set_i` pulse makes `bist_en_o` read 1. The bit clears at the edge where the strap vector is captured, so the next reset boots without self-test unless software sets it again.
- R5: `strap_oe_o` rises one edge after `cpu_rst_n_o` falls. The strap outputs stay stable for as long as `strap_oe_o` is high.
- R6: `cpu_rst_n_o` rises exactly `SETUP_CLKS`+1 edges after `strap_oe_o` rises (5 with the default of 4), so the pins are driven for at least 4 host clocks before release.
- R7: `strap_oe_o` falls exactly `HOLD_CLKS` edges (default 2) after `cpu_rst_n_o` rises, and the sequencer is idle again from that edge on.
- R8: A `warm_wr_i` pulse while a sequence is running has no effect. `warm_bit_o` stays 0 and no second reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_set_i | input | 1 | Software write that sets the self-test enable bit |
| warm_wr_i | input | 1 | Software write of the warm-reset bit |
| base_strap_i | input | ADDR_W | Base strap values for address pins 31..3 |
| base_init_n_i | input | 1 | Base strap value for the INIT pin |
| bist_en_o | output | 1 | Readback of the self-test enable bit |
| warm_bit_o | output | 1 | Readback of the self-clearing warm-reset bit |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| strap_addr_o | output | ADDR_W | Strap value for address pins 31..3 |
| strap_init_n_o | output | 1 | Strap value for the INIT pin |
| strap_oe_o | output | 1 | Output enable for the strap pins |

## Verification
Let E0 be the edge that samples a warm-reset write. Then `warm_bit_o` is 1 after E0, and the reset drops after E1. The strap drive starts after E2, the reset releases after E(3+SETUP_CLKS), and the drive ends after E(3+SETUP_CLKS+HOLD_CLKS). The bench computes each output for every edge count n from these formulas and samples 1 ns after each rising edge. Inputs change at those same points, so they are always stable at the next edge. Busy-time writes are inserted at random edge counts, and the full timeline is checked afterwards to show that no second reset started.

// File: rtl/rss_pkg.sv
package rss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_BUILD,
        ST_SETUP,
        ST_RELEASE,
        ST_HOLD
    } rss_state_e;
endpackage

// File: rtl/rss_ctl_bits.sv
// Software-visible control bits: self-test enable and self-clearing warm reset.
module rss_ctl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic bist_set_i,
    input  logic warm_wr_i,
    input  logic idle_i,
    input  logic start_i,
    input  logic sample_i,
    output logic bist_en_o,
    output logic warm_bit_o,
    output logic bist_req_o
);
    typedef struct packed {
        logic bist_en;
        logic warm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (bist_set_i) begin
            ctl_d.bist_en = 1'b1;
        end
        if (sample_i) begin
            ctl_d.bist_en = 1'b0;
        end
        if (start_i) begin
            ctl_d.warm = 1'b0;
        end else if (idle_i && warm_wr_i) begin
            ctl_d.warm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // A set arriving on the sampling edge is folded into the vector.
    assign bist_req_o = ctl_q.bist_en | bist_set_i;
    assign bist_en_o  = ctl_q.bist_en;
    assign warm_bit_o = ctl_q.warm;

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i && !start_i |=> !warm_bit_o);
endmodule

// File: rtl/rss_vec_merge.sv
// Builds the strap vector: base values with the self-test bit replaced.
module rss_vec_merge #(
    parameter int ADDR_W   = 29,
    parameter int BIST_IDX = 6
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              bist_i,
    output logic [ADDR_W-1:0] vec_o
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == BIST_IDX) begin : g_bist
            assign vec_o[i] = bist_i;
        end else begin : g_pass
            assign vec_o[i] = base_i[i];
        end
    end
endmodule

// File: rtl/rss_interval.sv
// Loadable down-counter for the setup and hold intervals.
module rss_interval #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/reset_strap_seq.sv
module reset_strap_seq #(
    parameter int ADDR_W     = 29,
    parameter int BIST_IDX   = 6,
    parameter int SETUP_CLKS = 4,
    parameter int HOLD_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_set_i,
    input  logic              warm_wr_i,
    input  logic [ADDR_W-1:0] base_strap_i,
    input  logic              base_init_n_i,
    output logic              bist_en_o,
    output logic              warm_bit_o,
    output logic              cpu_rst_n_o,
    output logic [ADDR_W-1:0] strap_addr_o,
    output logic              strap_init_n_o,
    output logic              strap_oe_o
);
    import rss_pkg::*;

    localparam int MAXC = (SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SETUP_LOAD = CW'(SETUP_CLKS - 1);
    localparam logic [CW-1:0] HOLD_LOAD  = CW'(HOLD_CLKS - 2);

    typedef struct packed {
        rss_state_e        state;
        logic              cpu_rst_n;
        logic              oe;
        logic [ADDR_W-1:0] strap;
        logic              init_n;
    } seq_t;

    seq_t s_d, s_q;

    logic              idle, start, sample;
    logic              bist_req;
    logic [ADDR_W-1:0] merged;
    logic              cnt_load, cnt_dec, cnt_done;
    logic [CW-1:0]     cnt_val;

    assign idle   = (s_q.state == ST_IDLE);
    assign start  = idle && warm_bit_o;
    assign sample = (s_q.state == ST_ASSERT);

    rss_ctl_bits u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bist_set_i (bist_set_i),
        .warm_wr_i  (warm_wr_i),
        .idle_i     (idle),
        .start_i    (start),
        .sample_i   (sample),
        .bist_en_o  (bist_en_o),
        .warm_bit_o (warm_bit_o),
        .bist_req_o (bist_req)
    );

    rss_vec_merge #(
        .ADDR_W   (ADDR_W),
        .BIST_IDX (BIST_IDX)
    ) u_merge (
        .base_i (base_strap_i),
        .bist_i (bist_req),
        .vec_o  (merged)
    );

    rss_interval #(
        .CW (CW)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .done_o     (cnt_done)
    );

    always_comb begin
        s_d      = s_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = SETUP_LOAD;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state     = ST_ASSERT;
                    s_d.cpu_rst_n = 1'b0;
                end
            end
            ST_ASSERT: begin
                s_d.state  = ST_BUILD;
                s_d.strap  = merged;
                s_d.init_n = base_init_n_i;
                s_d.oe     = 1'b1;
            end
            ST_BUILD: begin
                s_d.state = ST_SETUP;
                cnt_load  = 1'b1;
                cnt_val   = SETUP_LOAD;
            end
            ST_SETUP: begin
                if (cnt_done) begin
                    s_d.state     = ST_RELEASE;
                    s_d.cpu_rst_n = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_RELEASE: begin
                s_d.state = ST_HOLD;
                cnt_load  = 1'b1;
                cnt_val   = HOLD_LOAD;
            end
            ST_HOLD: begin
                if (cnt_done) begin
                    s_d.state  = ST_IDLE;
                    s_d.oe     = 1'b0;
                    s_d.strap  = '0;
                    s_d.init_n = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state     <= ST_IDLE;
            s_q.cpu_rst_n <= 1'b1;
            s_q.oe        <= 1'b0;
            s_q.strap     <= '0;
            s_q.init_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_rst_n_o    = s_q.cpu_rst_n;
    assign strap_oe_o     = s_q.oe;
    assign strap_addr_o   = s_q.strap;
    assign strap_init_n_o = s_q.init_n;

    p_warm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_n_o) |-> !warm_bit_o);
    p_bist_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_oe_o) |-> !bist_en_o || $past(bist_set_i) && 1'b0 || !bist_en_o);
    p_oe_after_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_n_o) |=> strap_oe_o);
    p_strap_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strap_oe_o && $past(strap_oe_o) |-> $stable(strap_addr_o) && $stable(strap_init_n_o));
    p_release_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> strap_oe_o);
    p_handback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strap_oe_o) |-> cpu_rst_n_o);
endmodule

// File: tb/tb_reset_strap_seq.sv
module tb_reset_strap_seq;
    localparam int W = 29;
    localparam int BI = 6;
    localparam int S = 4;
    localparam int H = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bist_set = 1'b0;
    logic         warm_wr = 1'b0;
    logic [W-1:0] base = '0;
    logic         base_init_n = 1'b1;
    logic         bist_en, warm_bit, cpu_rst_n, init_n, oe;
    logic [W-1:0] strap;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reset_strap_seq #(.ADDR_W(W), .BIST_IDX(BI), .SETUP_CLKS(S), .HOLD_CLKS(H)) dut (
        .clk(clk), .rst_n(rst_n), .bist_set_i(bist_set), .warm_wr_i(warm_wr),
        .base_strap_i(base), .base_init_n_i(base_init_n),
        .bist_en_o(bist_en), .warm_bit_o(warm_bit), .cpu_rst_n_o(cpu_rst_n),
        .strap_addr_o(strap), .strap_init_n_o(init_n), .strap_oe_o(oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_vec(logic [W-1:0] b, logic arm);
        logic [W-1:0] v = b;
        v[BI] = arm;
        return v;
    endfunction

    function automatic logic exp_rst_n(int n);
        return !(n >= 1 && n <= 2 + S);
    endfunction

    function automatic logic exp_oe(int n);
        return (n >= 2 && n <= 2 + S + H);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One sequence; busy_at >= 2 inserts a warm write sampled at that edge count.
    task automatic run_seq(logic [W-1:0] b, logic ini, logic arm, int busy_at);
        logic [W-1:0] ev;
        base = b;
        base_init_n = ini;
        if (arm) begin
            bist_set = 1'b1;
            step();
            bist_set = 1'b0;
            chk("R4 enable set", 32'(bist_en), 32'd1);
        end
        ev = exp_vec(b, arm);
        warm_wr = 1'b1;
        for (int n = 0; n <= S + H + 5; n++) begin
            step();
            warm_wr = (n + 1 == busy_at) ? 1'b1 : 1'b0;
            chk("R2 warm bit", 32'(warm_bit), 32'(n == 0));
            chk("R6 cpu reset", 32'(cpu_rst_n), 32'(exp_rst_n(n)));
            chk("R7 output enable", 32'(oe), 32'(exp_oe(n)));
            if (n >= 2) chk("R4 enable cleared", 32'(bist_en), 32'd0);
            if (exp_oe(n)) begin
                chk("R3 strap addr", 32'(strap), 32'(ev));
                chk("R3 strap init", 32'(init_n), 32'(ini));
                chk("R5 strap bist bit", 32'(strap[BI]), 32'(arm));
            end
        end
        warm_wr = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 no second reset", 32'(cpu_rst_n), 32'd1);
            chk("R8 warm bit idle", 32'(warm_bit), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 cpu reset", 32'(cpu_rst_n), 32'd1);
        chk("R1 oe", 32'(oe), 32'd0);
        chk("R1 strap", 32'(strap), 32'd0);
        chk("R1 init", 32'(init_n), 32'd1);
        chk("R1 warm", 32'(warm_bit), 32'd0);
        chk("R1 bist", 32'(bist_en), 32'd0);
        rst_n = 1'b1;
        step();
        // directed corners
        run_seq('0, 1'b1, 1'b1, 0);
        run_seq({W{1'b1}}, 1'b0, 1'b0, 0);
        run_seq(29'h0AAA_AAAA, 1'b1, 1'b0, 2);
        run_seq(29'h1555_5555, 1'b0, 1'b1, 2 + S + H);
        void'($urandom(32'd1234));
        for (int it = 0; it < 30; it++) begin
            logic [W-1:0] rb = W'($urandom);
            logic ri = 1'($urandom);
            logic ra = 1'($urandom);
            int bz = ($urandom % 2) ? 2 + int'($urandom % (S + H + 1)) : 0;
            run_seq(rb, ri, ra, bz);
            repeat ($urandom % 4) step();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule